// File: doc/BRIEF.md
# Digit-Serial by Parallel Two's Complement Multiplier

The block forms the product of a serially delivered two's complement data word and a two's complement coefficient held in parallel. The data word of `W` bits is cut into digits of `N` bits, so one word lasts `P = W/N` clocks. That interval is the sample period. Digits arrive one per clock, lowest digit first. A start-of-word strobe marks the first digit of every word. Words may follow one another with no idle cycle between them.

On each accepted digit the block multiplies the digit by the coefficient with shift-and-add. It adds this partial product to a residue that moves down by `N` bits every cycle. It then emits the `N` lowest settled product bits as an output digit. After the last digit of a word it presents the upper `WC` product bits in parallel, with a one-cycle valid strobe.

The top bit of the final digit carries negative weight. The coefficient is sampled only on the start-of-word cycle. A fresh strobe always restarts the accumulation from nothing, so each word costs exactly `P` cycles.

Top module: `dser_mul`

## Requirements
- R1: While reset is held, and on the first cycle after it, `digit_o`, `high_o` and `high_vld_o` are all zero.
- R2: A digit accepted at a clock edge shows on `digit_o` after that same edge. For the digit with index k (0 = lowest), `digit_o` equals bits [kN+N-1 : kN] of the full (W+WC)-bit two's complement product of the word and its coefficient.
- R3: After the edge that accepts digit P-1 of a word, `high_o` holds product bits [W+WC-1 : W] and `high_vld_o` is 1. `high_vld_o` returns to 0 on the next cycle unless that cycle also ends a word.
- R4: The data word is two's complement. Bit N-1 of the final digit weighs -2^(W-1), so words with the top bit set, including the most negative word, give signed products.
- R5: A word whose start strobe comes on the cycle right after the previous word's last digit is computed with no residue from the earlier word and no lost cycle.
- R6: `coef_i` is sampled only on the cycle where `sow_i` is 1. Values on `coef_i` in the other cycles of the word do not change that word's outputs.
- R7: If `sow_i` is raised before a word is complete, the partial word is dropped without a `high_vld_o` pulse, and the new word is computed correctly.
- R8: When a word is complete and `sow_i` is low, the digit input is ignored: `digit_o` keeps its value and `high_vld_o` stays 0 until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sow_i | input | 1 | Start of word; high on the cycle of a word's lowest digit |
| digit_i | input | N | Data digit, lowest digit of the word first |
| coef_i | input | WC | Two's complement coefficient, sampled when `sow_i` is 1 |
| digit_o | output | N | Settled low product digit, registered |
| high_o | output | WC | Upper product bits, registered, updated at word end |
| high_vld_o | output | 1 | One-cycle strobe marking `high_o` as fresh |

## Verification
Directed words cover the sign corners: most negative by most negative, largest positive squared, minus one by one, and most negative by largest positive. These catch a lost carry, a missing sign extension and an unweighted top digit. Constrained random traffic then mixes four patterns. Back-to-back words show whether residue leaks across a boundary. Words whose coefficient input toggles mid-word tell the sampled coefficient apart from the live one. Early restarts show that an aborted word leaves nothing behind. Idle gaps show that stray digits are really ignored.

// File: rtl/dsmul_pkg.sv
package dsmul_pkg;

  // Number of digits that make up one data word (the sample period).
  function automatic int digit_count(input int word_bits, input int digit_bits);
    return word_bits / digit_bits;
  endfunction

  // Width of a counter able to index P digits (never zero wide).
  function automatic int index_bits(input int p);
    return (p > 1) ? $clog2(p) : 1;
  endfunction

endpackage

// File: rtl/dsmul_digit_ctrl.sv
module dsmul_digit_ctrl #(
  parameter int P = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sow,
  output logic take,
  output logic last
);
  localparam int CW = dsmul_pkg::index_bits(P);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;

  // A start strobe always wins and resets the digit index.
  always_comb begin
    idx  = sow ? '0 : cnt_q;
    take = sow | active_q;
    last = take && (idx == CW'(P - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take) begin
      if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dsmul_pp.sv
module dsmul_pp #(
  parameter int N  = 2,
  parameter int WC = 8
) (
  input  logic [N-1:0]         digit,
  input  logic [WC-1:0]        coef,
  input  logic                 neg_top,
  output logic signed [WC+N:0] pp
);
  localparam int PW = WC + N + 1;

  logic signed [PW-1:0] cext;
  logic signed [PW-1:0] term [N];
  logic signed [PW-1:0] part [N+1];

  assign cext    = PW'($signed(coef));
  assign part[0] = '0;

  // One shifted copy of the coefficient per digit bit; the top bit of
  // the sign-carrying digit is subtracted instead of added.
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign term[i] = digit[i] ? (cext <<< i) : '0;
    if (i == N - 1) begin : g_top
      assign part[i+1] = neg_top ? (part[i] - term[i]) : (part[i] + term[i]);
    end else begin : g_low
      assign part[i+1] = part[i] + term[i];
    end
  end

  assign pp = part[N];
endmodule

// File: rtl/dsmul_accum.sv
module dsmul_accum #(
  parameter int N  = 2,
  parameter int WC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic                 first,
  input  logic                 last,
  input  logic signed [WC+N:0] pp,
  output logic [N-1:0]         digit_o,
  output logic [WC-1:0]        high_o,
  output logic                 high_vld_o
);
  localparam int AW = WC + N + 1;

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] base;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] shifted;

  always_comb begin
    base    = first ? '0 : acc_q;
    sum     = base + pp;
    shifted = sum >>> N;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      digit_o    <= '0;
      high_o     <= '0;
      high_vld_o <= 1'b0;
    end else begin
      high_vld_o <= take && last;
      if (take) begin
        digit_o <= sum[N-1:0];
        acc_q   <= last ? '0 : shifted;
        if (last) begin
          high_o <= shifted[WC-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dser_mul.sv
module dser_mul #(
  parameter int W  = 8,
  parameter int N  = 2,
  parameter int WC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sow_i,
  input  logic [N-1:0]  digit_i,
  input  logic [WC-1:0] coef_i,
  output logic [N-1:0]  digit_o,
  output logic [WC-1:0] high_o,
  output logic          high_vld_o
);
  localparam int P = dsmul_pkg::digit_count(W, N);

  if ((W % N) != 0 || N < 1) begin : g_bad_digit
    $error("digit width must divide word width");
  end

  logic                 take;
  logic                 last;
  logic [WC-1:0]        coef_q;
  logic [WC-1:0]        coef_use;
  logic signed [WC+N:0] pp;

  // Coefficient is captured on the start strobe and held for the word.
  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q <= '0;
    end else if (sow_i) begin
      coef_q <= coef_i;
    end
  end

  assign coef_use = sow_i ? coef_i : coef_q;

  dsmul_digit_ctrl #(.P(P)) ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .sow  (sow_i),
    .take (take),
    .last (last)
  );

  dsmul_pp #(.N(N), .WC(WC)) pp_i (
    .digit   (digit_i),
    .coef    (coef_use),
    .neg_top (last),
    .pp      (pp)
  );

  dsmul_accum #(.N(N), .WC(WC)) acc_i (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .first      (sow_i),
    .last       (last),
    .pp         (pp),
    .digit_o    (digit_o),
    .high_o     (high_o),
    .high_vld_o (high_vld_o)
  );
endmodule

// File: rtl/dser_mul_chk.sv
module dser_mul_chk #(
  parameter int W = 8,
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         sow_i,
  input logic [N-1:0] digit_o,
  input logic         high_vld_o
);
  localparam int P  = W / N;
  localparam int SW = $clog2(P + 1);

  logic [SW-1:0] seen;
  logic          rst_q = 1'b0;

  // Independent count of digits consumed in the current word.
  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else if (sow_i) begin
      seen <= SW'(1);
    end else if (seen != '0 && seen < SW'(P)) begin
      seen <= seen + SW'(1);
    end else begin
      seen <= '0;
    end
  end

  // R1: outputs are cleared one cycle into reset.
  always @(posedge clk) begin
    if (rst_q) begin
      a_r1_reset_clears: assert (digit_o == '0 && !high_vld_o)
        else $error("reset did not clear outputs");
    end
    rst_q <= rst;
  end

  // R3: strobe exactly when P digits of one word have been taken.
  a_r3_valid_at_word_end: assert property (@(posedge clk) disable iff (rst)
    high_vld_o == (seen == SW'(P)));

  // R8: with no word in flight and no start, nothing moves.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!sow_i && (seen == '0 || seen == SW'(P))) |=> ($stable(digit_o) && !high_vld_o));

  if (P > 1) begin : g_multi
    // R3: strobe lasts a single cycle.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
      high_vld_o |=> !high_vld_o);

    // R7: a restart mid-word gives no strobe for the abandoned word.
    a_r7_abort_no_strobe: assert property (@(posedge clk) disable iff (rst)
      (sow_i && seen != '0 && seen != SW'(P)) |=> !high_vld_o);
  end
endmodule

bind dser_mul dser_mul_chk #(.W(W), .N(N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sow_i      (sow_i),
  .digit_o    (digit_o),
  .high_vld_o (high_vld_o)
);

// File: tb/dser_mul_tb_top.sv
`timescale 1ns/1ps
module dser_mul_tb_top;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int WC = 8;
  localparam int P  = W / N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sow_i = 1'b0;
  logic [N-1:0]  digit_i = '0;
  logic [WC-1:0] coef_i = '0;
  logic [N-1:0]  digit_o;
  logic [WC-1:0] high_o;
  logic          high_vld_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit            e_dchk = 1'b0;
  logic [N-1:0]  e_d = '0;
  bit            e_hv = 1'b0;
  logic [WC-1:0] e_hi = '0;
  string         e_rq = "R2";
  logic [N-1:0]  exp_last = '0;

  always #2.5 clk = ~clk;

  dser_mul #(.W(W), .N(N), .WC(WC)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .sow_i      (sow_i),
    .digit_i    (digit_i),
    .coef_i     (coef_i),
    .digit_o    (digit_o),
    .high_o     (high_o),
    .high_vld_o (high_vld_o)
  );

  function automatic logic [W+WC-1:0] prod(input logic [W-1:0] d, input logic [WC-1:0] c);
    logic signed [W+WC-1:0] a;
    logic signed [W+WC-1:0] b;
    a = {{WC{d[W-1]}}, d};
    b = {{W{c[WC-1]}}, c};
    return a * b;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Check the outputs due from the previous digit, then drive the next one.
  task automatic tick(input logic s, input logic [N-1:0] d, input logic [WC-1:0] cf,
                      input bit dchk, input logic [N-1:0] ed, input bit ehv,
                      input logic [WC-1:0] ehi, input string rq);
    @(negedge clk);
    if (e_dchk) check(digit_o == e_d, e_rq, int'(digit_o), int'(e_d));
    check(high_vld_o == e_hv, "R3", int'(high_vld_o), int'(e_hv));
    if (e_hv) check(high_o == e_hi, {e_rq, " R3"}, int'(high_o), int'(e_hi));
    sow_i   = s;
    digit_i = d;
    coef_i  = cf;
    e_dchk  = dchk;
    e_d     = ed;
    e_hv    = ehv;
    e_hi    = ehi;
    e_rq    = rq;
    if (dchk) exp_last = ed;
  endtask

  task automatic word(input logic [W-1:0] d, input logic [WC-1:0] cf, input bit chg,
                      input string rq);
    logic [W+WC-1:0] p;
    p = prod(d, cf);
    for (int k = 0; k < P; k++) begin
      logic [WC-1:0] c;
      c = (k == 0 || !chg) ? cf : WC'($urandom);
      tick(k == 0, d[k*N +: N], c, 1'b1, p[k*N +: N], k == P - 1, p[W +: WC], rq);
    end
  endtask

  // R7: start a word and abandon it after m digits.
  task automatic partial(input logic [W-1:0] d, input logic [WC-1:0] cf, input int m);
    logic [W+WC-1:0] p;
    p = prod(d, cf);
    for (int k = 0; k < m; k++) begin
      tick(k == 0, d[k*N +: N], cf, 1'b1, p[k*N +: N], 1'b0, '0, "R7");
    end
  endtask

  // R8: stray digits with no start strobe.
  task automatic idle();
    tick(1'b0, N'($urandom), WC'($urandom), 1'b1, exp_last, 1'b0, '0, "R8");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(digit_o == '0, "R1", int'(digit_o), 0);
    check(high_o == '0, "R1", int'(high_o), 0);
    check(high_vld_o == 1'b0, "R1", int'(high_vld_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(digit_o == '0 && high_vld_o == 1'b0, "R1", int'(digit_o), 0);
    idle();

    // Directed sign corners.
    word(8'h80, 8'h80, 1'b0, "R4");
    word(8'h7F, 8'h7F, 1'b0, "R2");
    word(8'hFF, 8'h01, 1'b0, "R4");
    word(8'h80, 8'h7F, 1'b0, "R4");
    word(8'h01, 8'hFF, 1'b0, "R2");
    word(8'h00, 8'hA5, 1'b0, "R5");
    word(8'h5A, 8'h33, 1'b1, "R6");
    partial(8'hC3, 8'h81, 2);
    word(8'hFE, 8'h80, 1'b0, "R7");
    idle();
    idle();

    for (int i = 0; i < 300; i++) begin
      int mode;
      logic [W-1:0]  d;
      logic [WC-1:0] c;
      mode = int'($urandom % 6);
      d    = W'($urandom);
      c    = WC'($urandom);
      case (mode)
        0: begin
          for (int j = 0; j <= int'($urandom % 3); j++) idle();
        end
        1: begin
          if (P > 1) partial(d, c, 1 + int'($urandom % (P - 1)));
          word(W'($urandom), WC'($urandom), 1'b0, "R7");
        end
        2: word(d, c, 1'b1, "R6");
        default: word(d, c, 1'b0, d[W-1] ? "R4" : "R5");
      endcase
    end
    idle();
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule